// File: doc/BRIEF.md
# Temperature-Aware Refresh Scheduler

This block paces periodic refresh for a DDR3-style memory controller. A down-counter measures the average refresh interval in controller clocks. Each time the counter expires it adds one to a saturating count of owed refreshes. The block asks the command arbiter for a refresh whenever it owes one and no recovery window is open. When the arbiter grants that request, the block opens a busy window. The window keeps every other command off the bus for the refresh recovery time.

In the extended temperature range the interval is half the normal one. A range change is applied only when the counter reloads, so an interval that is already running is never cut short. The recovery length comes from the speed-bin parameter, which sets the clock period. The block also supplies the two mode-register bits (A7, A6) that select the self-refresh temperature behaviour for the current range. All state advances only on cycles where the clock-enable tick is high.

Top module: `refresh_sched`

## Requirements
- R1: After reset the first refresh becomes owed on the NORM_CYC-th tick, where NORM_CYC is 7.8 us divided by the clock period (6240 with the default bin). With the range normal at each reload, every later interval is NORM_CYC ticks long.
- R2: When the temperature flag is high at a reload, the next interval lasts EXT_CYC = NORM_CYC/2 ticks (3120 by default).
- R3: A change of the temperature flag has no effect on the interval that is already running. It is applied at the next reload.
- R4: `refReq` is high exactly while the owed count is non-zero and `busy` is low, and it stays high until a grant is taken. The owed count stops at PEND_MAX (8). When a refresh falls due on the same tick that a grant is taken, the count is unchanged.
- R5: A grant taken on a tick (tick, grant and refReq all high) lowers the owed count by one and raises `busy` after that edge. `busy` then stays high for exactly RFC_CYC ticks.
- R6: RFC_CYC is the 110 ns recovery rounded up to whole clocks: 88 for bin 0 (1.25 ns), 74 for bin 1 (1.5 ns) and 59 for bin 2 (1.875 ns).
- R7: A grant while `refReq` is low (nothing owed, or busy high) has no effect on the owed count or on `busy`.
- R8: `srtBits` = {A7, A6} is updated on every tick from the temperature flag. It is 2'b00 for the normal range. For the extended range it is 2'b10 with manual extended self-refresh (AUTO_SELF_REFRESH = 0) and 2'b01 with auto self-refresh (AUTO_SELF_REFRESH = 1).
- R9: On cycles with `tick` low, the interval counter, the owed count, the busy window and `srtBits` all hold their values.
- R10: During reset, the owed count is zero and `refReq`, `busy` and `srtBits` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock enable; state advances only when high |
| extTemp | input | 1 | High selects the extended temperature range |
| grant | input | 1 | Arbiter issues the requested refresh |
| refReq | output | 1 | Refresh requested |
| pendCount | output | PEND_W (4) | Number of owed refreshes |
| busy | output | 1 | Recovery window; other commands blocked |
| srtBits | output | 2 | Mode-register self-refresh temperature bits {A7, A6} |

## Verification
Every result appears one edge after the stimulus that causes it. An owed refresh shows in `pendCount` after the tick whose number equals the interval. A taken grant shows as a lower count and a high `busy` after the grant edge. `busy` falls after the RFC_CYC-th further tick, and `srtBits` follows the flag one edge later. The bench drives inputs and samples outputs on falling edges. It keeps its own count of rising edges since reset, moves to the edge just before each expected change and checks the old value there, then steps one more edge and checks the new value. For pauses in the tick, it adds the number of frozen edges to its expected times.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

  typedef struct packed {
    logic reloadInt;
    logic stepInt;
    logic addPend;
    logic subPend;
    logic loadBusy;
    logic stepBusy;
    logic sampleTemp;
  } schedStrobes_t;

  typedef struct packed {
    logic intDone;
    logic pendEmpty;
    logic pendFull;
    logic busyOn;
  } schedStatus_t;

  function automatic int clkPeriodPs(input int bin);
    case (bin)
      1:       return 1500;
      2:       return 1875;
      default: return 1250;
    endcase
  endfunction

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/refresh_sched_ctrl.sv
module refresh_sched_ctrl
  import refresh_sched_pkg::*;
(
  input  logic          tick,
  input  logic          grant,
  input  schedStatus_t  status,
  output schedStrobes_t strobes,
  output logic          refReq
);

  logic accept;
  logic due;

  always_comb begin
    refReq = !status.pendEmpty && !status.busyOn;
    accept = tick && grant && refReq;
    due    = tick && status.intDone;

    strobes.reloadInt  = due;
    strobes.stepInt    = tick && !status.intDone;
    // a due refresh is dropped only when the count is full and nothing drains
    strobes.addPend    = due && (!status.pendFull || accept);
    strobes.subPend    = accept;
    strobes.loadBusy   = accept;
    strobes.stepBusy   = tick && status.busyOn;
    strobes.sampleTemp = tick;
  end

endmodule

// File: rtl/refresh_sched_dp.sv
module refresh_sched_dp
  import refresh_sched_pkg::*;
#(
  parameter int NORM_CYC          = 6240,
  parameter int EXT_CYC           = 3120,
  parameter int RFC_CYC           = 88,
  parameter int PEND_MAX          = 8,
  parameter int PEND_W            = 4,
  parameter bit AUTO_SELF_REFRESH = 1'b0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          extTemp,
  input  schedStrobes_t strobes,
  output schedStatus_t  status,
  output logic [PEND_W-1:0] pendCount,
  output logic          busy,
  output logic [1:0]    srtBits
);

  localparam int INT_W  = $clog2(NORM_CYC);
  localparam int BUSY_W = $clog2(RFC_CYC + 1);

  logic [INT_W-1:0]  intCnt;
  logic [PEND_W-1:0] pendCnt;
  logic [BUSY_W-1:0] busyCnt;
  logic [1:0]        srtReg;
  logic [1:0]        extCode;

  generate
    if (AUTO_SELF_REFRESH) begin : g_autoSr
      assign extCode = 2'b01;
    end else begin : g_manualSr
      assign extCode = 2'b10;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intCnt <= INT_W'(NORM_CYC - 1);
    end else if (strobes.reloadInt) begin
      intCnt <= extTemp ? INT_W'(EXT_CYC - 1) : INT_W'(NORM_CYC - 1);
    end else if (strobes.stepInt) begin
      intCnt <= intCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCnt <= '0;
    end else begin
      case ({strobes.addPend, strobes.subPend})
        2'b10:   pendCnt <= pendCnt + 1'b1;
        2'b01:   pendCnt <= pendCnt - 1'b1;
        default: pendCnt <= pendCnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (strobes.loadBusy) begin
      busyCnt <= BUSY_W'(RFC_CYC);
    end else if (strobes.stepBusy) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srtReg <= 2'b00;
    end else if (strobes.sampleTemp) begin
      srtReg <= extTemp ? extCode : 2'b00;
    end
  end

  assign status.intDone   = (intCnt == '0);
  assign status.pendEmpty = (pendCnt == '0);
  assign status.pendFull  = (pendCnt == PEND_W'(PEND_MAX));
  assign status.busyOn    = (busyCnt != '0);

  assign pendCount = pendCnt;
  assign busy      = status.busyOn;
  assign srtBits   = srtReg;

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_sched_pkg::*;
#(
  parameter int SPEED_BIN         = 0,
  parameter bit AUTO_SELF_REFRESH = 1'b0,
  parameter int PEND_MAX          = 8,
  parameter int INTERVAL_PS       = 7800000,
  parameter int RFC_PS            = 110000,
  localparam int PEND_W           = $clog2(PEND_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              extTemp,
  input  logic              grant,
  output logic              refReq,
  output logic [PEND_W-1:0] pendCount,
  output logic              busy,
  output logic [1:0]        srtBits
);

  localparam int CLK_PS   = clkPeriodPs(SPEED_BIN);
  localparam int NORM_CYC = INTERVAL_PS / CLK_PS;
  localparam int EXT_CYC  = NORM_CYC / 2;
  localparam int RFC_CYC  = ceilDiv(RFC_PS, CLK_PS);
  localparam logic [1:0] EXT_CODE = AUTO_SELF_REFRESH ? 2'b01 : 2'b10;

  schedStrobes_t strobes;
  schedStatus_t  status;

  refresh_sched_ctrl u_ctrl (
    .tick    (tick),
    .grant   (grant),
    .status  (status),
    .strobes (strobes),
    .refReq  (refReq)
  );

  refresh_sched_dp #(
    .NORM_CYC          (NORM_CYC),
    .EXT_CYC           (EXT_CYC),
    .RFC_CYC           (RFC_CYC),
    .PEND_MAX          (PEND_MAX),
    .PEND_W            (PEND_W),
    .AUTO_SELF_REFRESH (AUTO_SELF_REFRESH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .extTemp   (extTemp),
    .strobes   (strobes),
    .status    (status),
    .pendCount (pendCount),
    .busy      (busy),
    .srtBits   (srtBits)
  );

endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int RFC_CYC           = 88,
  parameter int PEND_MAX          = 8,
  parameter int PEND_W            = 4,
  parameter logic [1:0] EXT_CODE  = 2'b10
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              extTemp,
  input logic              grant,
  input logic              refReq,
  input logic [PEND_W-1:0] pendCount,
  input logic              busy,
  input logic [1:0]        srtBits
);

  int busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= 0;
    else if (tick && grant && refReq) busyRun <= 0;
    else if (busy && tick) busyRun <= busyRun + 1;
  end

  a_r5_busy_after_grant: assert property (@(posedge clk) disable iff (!rstN)
    (tick && grant && refReq) |=> busy);

  a_r5_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == RFC_CYC));

  a_r7_no_req_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !refReq);

  a_r4_no_req_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    (pendCount == '0) |-> !refReq);

  a_r4_pend_limit: assert property (@(posedge clk) disable iff (!rstN)
    pendCount <= PEND_W'(PEND_MAX));

  a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> ($stable(pendCount) && $stable(busy) && $stable(srtBits)));

  a_r8_srt_code: assert property (@(posedge clk) disable iff (!rstN)
    (tick && extTemp) |=> (srtBits == EXT_CODE));

  a_r8_srt_normal: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !extTemp) |=> (srtBits == 2'b00));

endmodule

bind refresh_sched refresh_sched_chk #(
  .RFC_CYC  (RFC_CYC),
  .PEND_MAX (PEND_MAX),
  .PEND_W   (PEND_W),
  .EXT_CODE (EXT_CODE)
) chk (
  .clk       (clk),
  .rstN      (rstN),
  .tick      (tick),
  .extTemp   (extTemp),
  .grant     (grant),
  .refReq    (refReq),
  .pendCount (pendCount),
  .busy      (busy),
  .srtBits   (srtBits)
);

// File: tb/refresh_sched_test.sv
`timescale 1ns/1ps
module refresh_sched_test;

  localparam int NORM = 6240;
  localparam int EXT  = 3120;
  localparam int RFC  = 88;
  localparam int RFC2 = 59;
  localparam int PMAX = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b1;
  logic extTemp = 1'b0;
  logic grant = 1'b0;
  logic refReq, busy, refReq2, busy2;
  logic [3:0] pendCount, pendCount2;
  logic [1:0] srtBits, srtBits2;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  refresh_sched uut (
    .clk(clk), .rstN(rstN), .tick(tick), .extTemp(extTemp), .grant(grant),
    .refReq(refReq), .pendCount(pendCount), .busy(busy), .srtBits(srtBits)
  );

  refresh_sched #(.SPEED_BIN(2), .AUTO_SELF_REFRESH(1'b1)) uut2 (
    .clk(clk), .rstN(rstN), .tick(tick), .extTemp(extTemp), .grant(grant),
    .refReq(refReq2), .pendCount(pendCount2), .busy(busy2), .srtBits(srtBits2)
  );

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", tag, cyc, actual, expected);
    end
  endtask

  task automatic advance(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
    cyc += n;
  endtask

  task automatic goTo(input int target);
    advance(target - cyc);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    #12;
    @(negedge clk);
    check("R10 pend in reset", pendCount, 0);
    check("R10 req in reset", refReq, 0);
    check("R10 busy in reset", busy, 0);
    check("R10 srt in reset", srtBits, 0);
    rstN = 1'b1;
    cyc = 0;
  endtask

  task automatic testFirstInterval();
    goTo(NORM - 1);
    check("R1 not yet owed", pendCount, 0);
    advance(1);
    check("R1 owed at interval", pendCount, 1);
    check("R4 request raised", refReq, 1);
  endtask

  task automatic testGrantBusy();
    grant = 1'b1;
    advance(1);
    grant = 1'b0;
    check("R5 busy after grant", busy, 1);
    check("R5 pend after grant", pendCount, 0);
    check("R4 req dropped", refReq, 0);
    goTo(NORM + 1 + RFC2 - 1);
    check("R6 bin2 busy last", busy2, 1);
    advance(1);
    check("R6 bin2 busy end", busy2, 0);
    goTo(NORM + 1 + RFC - 1);
    check("R5 R6 busy last", busy, 1);
    advance(1);
    check("R5 R6 busy end", busy, 0);
  endtask

  task automatic testIdleGrant();
    grant = 1'b1;
    advance(1);
    grant = 1'b0;
    check("R7 idle grant busy", busy, 0);
    check("R7 idle grant pend", pendCount, 0);
  endtask

  task automatic testExtended();
    extTemp = 1'b1;
    advance(1);
    check("R8 manual ext code", srtBits, 2);
    check("R8 auto ext code", srtBits2, 1);
    goTo(NORM + EXT + 1);
    check("R3 running interval kept", pendCount, 0);
    goTo(2 * NORM - 1);
    check("R3 before normal due", pendCount, 0);
    advance(1);
    check("R3 due at normal length", pendCount, 1);
    goTo(2 * NORM + EXT - 1);
    check("R2 before ext due", pendCount, 1);
    check("R4 req held", refReq, 1);
    advance(1);
    check("R2 due at ext length", pendCount, 2);
  endtask

  task automatic testSaturate();
    goTo(2 * NORM + 6 * EXT - 1 + EXT);
    check("R4 seven owed", pendCount, 7);
    advance(1);
    check("R4 eight owed", pendCount, PMAX);
    goTo(2 * NORM + 8 * EXT);
    check("R4 saturated", pendCount, PMAX);
  endtask

  task automatic testDrainAndTick();
    int dueAt;
    int a;
    grant = 1'b1;
    advance(1);
    check("R5 drain one", pendCount, 7);
    check("R5 busy on", busy, 1);
    advance(RFC - 1);
    check("R7 grant in busy ignored", pendCount, 7);
    check("R5 busy still", busy, 1);
    advance(1);
    check("R5 busy released", busy, 0);
    check("R4 req back", refReq, 1);
    advance(1);
    check("R5 second drain", pendCount, 6);
    grant = 1'b0;
    tick = 1'b0;
    a = cyc;
    advance(200);
    check("R9 busy frozen", busy, 1);
    check("R9 pend frozen", pendCount, 6);
    tick = 1'b1;
    advance(RFC - 1);
    check("R9 busy counts ticks", busy, 1);
    advance(1);
    check("R9 busy ends after ticks", busy, 0);
    dueAt = 2 * NORM + 9 * EXT + 200;
    goTo(dueAt - 1);
    check("R9 interval paused", pendCount, 6);
    advance(1);
    check("R9 due shifted", pendCount, 7);
    extTemp = 1'b0;
    advance(1);
    check("R8 normal code", srtBits, 0);
    goTo(dueAt + EXT - 1);
    check("R3 ext reload kept", pendCount, 7);
    advance(1);
    check("R3 ext due", pendCount, 8);
    grant = 1'b1;
    advance(7 * (RFC + 1) + 1 + RFC);
    grant = 1'b0;
    check("R5 drained", pendCount, 0);
    check("R5 drained busy", busy, 0);
    check("R4 no req when empty", refReq, 0);
    goTo(dueAt + EXT + NORM - 1);
    check("R1 normal before due", pendCount, 0);
    advance(1);
    check("R1 normal restored", pendCount, 1);
    if (a < 0) check("unused", a, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testFirstInterval();
    testGrantBusy();
    testIdleGrant();
    testExtended();
    testSaturate();
    testDrainAndTick();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule